// File: doc/BRIEF.md
# Late-Write Four-Beat Burst Port with Byte Lanes

This block is the write side of a quad-data-rate style static memory, modelled in a single clock domain. One edge of the clock stands for a full input clock period: the data presented for the rising half (`d_rise`) and the falling half (`d_fall`) are both taken at that edge. A write command is taken from the active-low write select together with the write half of the shared address bus. The block holds that address in its own register and gathers four "late" data words over the next two clock edges. Each word carries its own active-low byte-lane enables over 9-bit lanes.

The four words of a burst land in sequential order in one line of an internal array, built as four word banks so that block RAM can be inferred. A command that arrives while a burst is half done is dropped. A command that arrives on the last data edge of a burst is taken, so back-to-back writes fill every half-cycle with data. A minimal read port returns a whole four-word line one edge after the read request, which lets the contents be seen from outside.

Top module: `lw_burst_port`

## Requirements
- R1: After synchronous reset, `rd_valid` is low and no write burst is in progress.
- R2: When `wr_n` is low at an edge where no burst is half done, the block takes `addr_w` as the write line address for a new burst.
- R3: For a command taken at edge n, `d_rise` and `d_fall` at edge n+1 become words 0 and 1, and `d_rise` and `d_fall` at edge n+2 become words 2 and 3 of the addressed line. A read returns word k in `rd_data[k*W +: W]`, with W = 9 × LANES.
- R4: Each word has active-low lane enables (`bw_rise_n` with `d_rise`, `bw_fall_n` with `d_fall`). Bit j gates data bits 9j to 9j+8. A high enable leaves those stored bits unchanged.
- R5: A write command at edge n+1 of a burst is ignored. The burst still completes at its original address, and the line named by the ignored command is not changed.
- R6: A command at edge n+2, the last data edge of a burst, is accepted. Back-to-back commands every second edge therefore capture data on every half-cycle.
- R7: Data and lane enables presented at edges that belong to no burst leave the array unchanged.
- R8: When `rd_n` is low at an edge, `rd_data` holds line `addr_r` after that edge and `rd_valid` is high for exactly that cycle. A read taken at the same edge as a burst write to the same line returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge covers a rising and a falling half of the input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_n | input | 1 | Active-low write command |
| addr_w | input | AW | Write line address (write half of the shared address bus) |
| d_rise | input | W | Data word for the rising half |
| d_fall | input | W | Data word for the falling half |
| bw_rise_n | input | LANES | Active-low lane enables for `d_rise` |
| bw_fall_n | input | LANES | Active-low lane enables for `d_fall` |
| rd_n | input | 1 | Active-low read request |
| addr_r | input | AW | Read line address (read half of the shared address bus) |
| rd_data | output | 4·W | The four words of the line that was read |
| rd_valid | output | 1 | `rd_data` holds a fresh read result |

## Verification
A corrupted sequencer phase shows up as words landing in the wrong bank or not at all. The first read of the burst's line after the burst exposes this, no later than three edges after the command. A write address register that changes mid-burst splits a burst across two lines, and reading both lines shows it. Lane decoding faults show up as bits that change in a masked lane, or bits that stay fixed in an enabled lane, of one word. Reads issued in the middle of a burst show whether the read path returns the old line or data mixed with the new write.

// File: rtl/wburst_pkg.sv
package wburst_pkg;
  localparam int LANE_W = 9;
  localparam int BEATS  = 4;

  typedef enum logic [1:0] {
    WB_IDLE = 2'd0,
    WB_LO   = 2'd1,
    WB_HI   = 2'd2
  } wb_phase_e;
endpackage

// File: rtl/wburst_seq.sv
module wburst_seq
  import wburst_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_n,
  input  logic [AW-1:0] addr_w,
  output logic          we_lo,
  output logic          we_hi,
  output logic [AW-1:0] waddr
);
  wb_phase_e phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= WB_IDLE;
      waddr <= '0;
    end else begin
      case (phase)
        WB_LO: phase <= WB_HI;
        default: begin
          if (!wr_n) begin
            phase <= WB_LO;
            waddr <= addr_w;
          end else begin
            phase <= WB_IDLE;
          end
        end
      endcase
    end
  end

  assign we_lo = (phase == WB_LO);
  assign we_hi = (phase == WB_HI);

  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    we_lo |=> we_hi);

  // R5
  waddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    we_lo |=> $stable(waddr));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_lo && !wr_n) |=> (we_lo && waddr == $past(addr_w)));

  // R7
  no_cmd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_lo && wr_n) |=> (!we_lo && !we_hi));
endmodule

// File: rtl/wburst_bank.sv
module wburst_bank
  import wburst_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         wa,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [LANES-1:0]      bw_n,
  input  logic                  re,
  input  logic [AW-1:0]         ra,
  output logic [LANES*LANE_W-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we && !bw_n[j]) mem[wa] <= din[j*LANE_W +: LANE_W];
      if (re) q <= mem[ra];
    end

    assign dout[j*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/lw_burst_port.sv
module lw_burst_port
  import wburst_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 2,
  localparam int W    = LANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_n,
  input  logic [AW-1:0]      addr_w,
  input  logic [W-1:0]       d_rise,
  input  logic [W-1:0]       d_fall,
  input  logic [LANES-1:0]   bw_rise_n,
  input  logic [LANES-1:0]   bw_fall_n,
  input  logic               rd_n,
  input  logic [AW-1:0]      addr_r,
  output logic [BEATS*W-1:0] rd_data,
  output logic               rd_valid
);
  logic          we_lo, we_hi;
  logic [AW-1:0] waddr;

  wburst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .wr_n(wr_n), .addr_w(addr_w),
    .we_lo(we_lo), .we_hi(we_hi), .waddr(waddr)
  );

  for (genvar k = 0; k < BEATS; k++) begin : g_bank
    logic [W-1:0] q;
    wburst_bank #(.AW(AW), .LANES(LANES)) u_bank (
      .clk (clk),
      .we  ((k < 2) ? we_lo : we_hi),
      .wa  (waddr),
      .din ((k % 2 == 0) ? d_rise : d_fall),
      .bw_n((k % 2 == 0) ? bw_rise_n : bw_fall_n),
      .re  (!rd_n),
      .ra  (addr_r),
      .dout(q)
    );
    assign rd_data[k*W +: W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= !rd_n;
  end

  // R8
  rd_valid_set_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |=> rd_valid);

  // R8
  rd_valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rd_n |=> !rd_valid);
endmodule

// File: tb/sim_lw_burst_port.sv
`timescale 1ns/1ps
module sim_lw_burst_port;
  localparam int AW = 4;
  localparam int LANES = 2;
  localparam int W = LANES * 9;
  localparam int LINES = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1;
  logic [AW-1:0] addr_w = '0;
  logic [W-1:0] d_rise = '0, d_fall = '0;
  logic [LANES-1:0] bw_rise_n = '1, bw_fall_n = '1;
  logic rd_n = 1'b1;
  logic [AW-1:0] addr_r = '0;
  logic [4*W-1:0] rd_data;
  logic rd_valid;

  int compared = 0;
  int mismatched = 0;
  logic [W-1:0] ref_m [LINES][4];

  always #5 clk = ~clk;

  lw_burst_port #(.AW(AW), .LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .wr_n(wr_n), .addr_w(addr_w),
    .d_rise(d_rise), .d_fall(d_fall), .bw_rise_n(bw_rise_n), .bw_fall_n(bw_fall_n),
    .rd_n(rd_n), .addr_r(addr_r), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [W-1:0] pat(input int line, input int k, input int salt);
    logic [31:0] v;
    v = (salt * 32'h0001_3579) ^ (line * 32'h0000_0243) ^ (k * 32'h0000_8081) ^ 32'h0002_a5c3;
    return v[W-1:0];
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply(input int line, input int k, input logic [W-1:0] d, input logic [LANES-1:0] bwn);
    for (int j = 0; j < LANES; j++)
      if (!bwn[j]) ref_m[line][k][j*9 +: 9] = d[j*9 +: 9];
  endtask

  task automatic check(input string tag, input logic [4*W-1:0] got, input logic [4*W-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [4*W-1:0] ref_line(input int line);
    return {ref_m[line][3], ref_m[line][2], ref_m[line][1], ref_m[line][0]};
  endfunction

  task automatic read_line(input int line, input string tag);
    rd_n = 1'b0; addr_r = AW'(line);
    tick();
    rd_n = 1'b1;
    check({tag, " rd_valid"}, {{(4*W-1){1'b0}}, rd_valid}, {{(4*W-1){1'b0}}, 1'b1});
    check(tag, rd_data, ref_line(line));
  endtask

  task automatic do_write(input int line, input logic [W-1:0] w [4], input logic [LANES-1:0] m [4]);
    wr_n = 1'b0; addr_w = AW'(line);
    tick();
    wr_n = 1'b1;
    d_rise = w[0]; bw_rise_n = m[0]; d_fall = w[1]; bw_fall_n = m[1];
    tick();
    d_rise = w[2]; bw_rise_n = m[2]; d_fall = w[3]; bw_fall_n = m[3];
    tick();
    bw_rise_n = '1; bw_fall_n = '1;
    for (int k = 0; k < 4; k++) apply(line, k, w[k], m[k]);
  endtask

  task automatic test_reset();
    // R1: read valid low after reset
    check("R1 rd_valid after reset", {{(4*W-1){1'b0}}, rd_valid}, '0);
  endtask

  task automatic test_stream();
    // R6: back-to-back commands every second edge; R3: beat order
    for (int i = 0; i < LINES; i++) begin
      wr_n = 1'b0; addr_w = AW'(i);
      if (i > 0) begin
        d_rise = pat(i-1, 2, 1); d_fall = pat(i-1, 3, 1);
        bw_rise_n = '0; bw_fall_n = '0;
      end
      tick();
      wr_n = 1'b1;
      d_rise = pat(i, 0, 1); d_fall = pat(i, 1, 1);
      bw_rise_n = '0; bw_fall_n = '0;
      tick();
      for (int k = 0; k < 4; k++) ref_m[i][k] = pat(i, k, 1);
    end
    d_rise = pat(LINES-1, 2, 1); d_fall = pat(LINES-1, 3, 1);
    tick();
    bw_rise_n = '1; bw_fall_n = '1;
    for (int i = 0; i < LINES; i++) read_line(i, $sformatf("R6/R3 stream line %0d", i));
  endtask

  task automatic test_lanes();
    logic [W-1:0] w [4];
    logic [LANES-1:0] m [4];
    // R4: lane 0 only, lane 1 only, none, both
    for (int k = 0; k < 4; k++) w[k] = pat(3, k, 7);
    m[0] = 2'b10; m[1] = 2'b01; m[2] = 2'b11; m[3] = 2'b00;
    do_write(3, w, m);
    read_line(3, "R4 byte lanes line 3");
    m[0] = 2'b01; m[1] = 2'b10; m[2] = 2'b10; m[3] = 2'b11;
    for (int k = 0; k < 4; k++) w[k] = pat(9, k, 11);
    do_write(9, w, m);
    read_line(9, "R4 byte lanes line 9");
  endtask

  task automatic test_interrupt();
    // R5: command one edge into a burst is dropped
    wr_n = 1'b0; addr_w = AW'(5);
    tick();
    addr_w = AW'(6);
    d_rise = pat(5, 0, 21); d_fall = pat(5, 1, 21); bw_rise_n = '0; bw_fall_n = '0;
    tick();
    wr_n = 1'b1; addr_w = AW'(5);
    d_rise = pat(5, 2, 21); d_fall = pat(5, 3, 21);
    tick();
    bw_rise_n = '1; bw_fall_n = '1;
    for (int k = 0; k < 4; k++) ref_m[5][k] = pat(5, k, 21);
    read_line(5, "R5 burst completes at first address");
    read_line(6, "R5 interrupting line untouched");
  endtask

  task automatic test_discard();
    // R7: data without a command is dropped
    wr_n = 1'b1; bw_rise_n = '0; bw_fall_n = '0;
    addr_w = AW'(0);
    for (int c = 0; c < 3; c++) begin
      d_rise = pat(c, 0, 33); d_fall = pat(c, 1, 33);
      tick();
    end
    bw_rise_n = '1; bw_fall_n = '1;
    read_line(0, "R7 line 0 unchanged");
    read_line(12, "R7 line 12 unchanged");
  endtask

  task automatic test_rdw();
    logic [4*W-1:0] old;
    // R8: read at the first data edge of a burst to the same line returns old data
    old = ref_line(10);
    wr_n = 1'b0; addr_w = AW'(10);
    tick();
    wr_n = 1'b1;
    rd_n = 1'b0; addr_r = AW'(10);
    d_rise = pat(10, 0, 44); d_fall = pat(10, 1, 44); bw_rise_n = '0; bw_fall_n = '0;
    tick();
    rd_n = 1'b1;
    check("R8 read during write old data", rd_data, old);
    d_rise = pat(10, 2, 44); d_fall = pat(10, 3, 44);
    tick();
    bw_rise_n = '1; bw_fall_n = '1;
    // R8: valid pulse lasts one cycle
    check("R8 rd_valid one cycle", {{(4*W-1){1'b0}}, rd_valid}, '0);
    for (int k = 0; k < 4; k++) ref_m[10][k] = pat(10, k, 44);
    read_line(10, "R8 new data after burst");
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_stream();
    test_lanes();
    test_interrupt();
    test_discard();
    test_rdw();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule